// File: doc/BRIEF.md
# Windowed Watchdog Timer

The block supervises software with a free-running 7-bit down-counter. A prescaler divides the bus clock by a power of two. Its base divide is set by a parameter, and a 2-bit select field adds a further factor of 1, 2, 4 or 8. Each prescaler tick moves the counter down by one. The counter runs from reset onward, and arming the watchdog does not start or change it.

Once armed, the watchdog stays armed until the system reset input is asserted. While it is armed, it drives a fixed-length reset pulse in three cases:

- the counter leaves its midpoint value (bit 6 drops to 0 on a tick);
- software writes a counter value whose bit 6 is clear, which acts as a deliberate reset request;
- software reloads the counter while the counter is still above the programmed window value.

An early-warning flag rises one tick before the timeout. It raises an interrupt if the enable bit allows it.

Software reaches the block through a plain single-cycle register port. A write takes effect at the clock edge where `reg_en` and `reg_wr` are both high. Read data is combinational from the addressed register. The port moves no streaming data, so it has no valid/ready handshake and no back-pressure.

Top module: `win_watchdog`

## Requirements
- R1: After the system reset: the watchdog is disarmed, the counter and the window value read 0x7F, the select field is 0, the enable and the flag are 0, and `wdg_rst` is low.
- R2: Writing 1 to bit 7 of the control register (offset 0x0) arms the watchdog. A later control write with bit 7 at 0 leaves it armed. Bit 7 of a control read shows the armed state.
- R3: The counter decrements by one, wrapping from 0x00 to 0x7F, at each bus-clock edge where the prescaler count has its low (BASE_LOG2 + sel) bits all ones. The prescaler count starts at 0 after reset and advances every cycle. This holds whether the watchdog is armed or not. Bits 6:0 of a control read return the counter.
- R4: While the watchdog is armed, a tick that moves the counter from 0x40 to 0x3F starts the reset pulse at that edge.
- R5: While the watchdog is armed, or on the write that arms it, a control write with bit 6 clear starts the reset pulse at that edge.
- R6: While the watchdog is armed, a control write starts the reset pulse if the counter is greater than the window (configuration bits 6:0, offset 0x4). A write made when the counter equals the window, or is below it and at least 0x40, causes no reset.
- R7: The flag (status bit 0, offset 0x8) is set at the tick that moves the counter from 0x41 to 0x40. `ew_irq` is high while the flag and the enable (configuration bit 9) are both 1.
- R8: A status write with bit 0 at 0 clears the flag. A status write with bit 0 at 1 leaves the flag unchanged.
- R9: Writing 1 to configuration bit 9 sets the enable. A later configuration write with bit 9 at 0 does not clear it.
- R10: The reset pulse holds `wdg_rst` high for exactly PULSE_LEN cycles, starting in the cycle after the triggering edge.
- R11: While the watchdog is disarmed, no counter value, reload or write with bit 6 clear produces a reset pulse.
- R12: A control write loads bits 6:0 into the counter. Any tick at that same edge is lost. The prescaler is not cleared by the write, so the next tick keeps its free-running phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low system reset, returns all state to reset values |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset: 0x0 control, 0x4 configuration, 0x8 status |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data of the addressed register |
| wdg_rst | output | 1 | System reset request pulse |
| ew_irq | output | 1 | Early-warning interrupt |

## Verification
The hardest cases to reach are the timing-dependent ones: the timeout edge and the window boundary, because both depend on a prescaler phase that software cannot see or clear. The bench builds the design with a tiny base divider. It counts bus-clock edges since reset and derives the edge of every tick arithmetically from that count and the selected period. From this it predicts, cycle by cycle, the counter, the flag and the reset pulse, for reloads made at varied phases and for every select value. The window boundary is reached by arming with a value exactly one above the window, or exactly at it, and then reloading on the very next cycle, before any tick can move the counter.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W = 7;
  localparam int SEL_W = 2;
  localparam logic [CNT_W-1:0] CNT_RESET = 7'h7F;
  localparam logic [CNT_W-1:0] WIN_RESET = 7'h7F;

  localparam int OFS_CTL = 'h0;
  localparam int OFS_CFG = 'h4;
  localparam int OFS_STS = 'h8;

  localparam int CTL_ARM_BIT = 7;
  localparam int CFG_W = 1 + SEL_W + CNT_W;

  typedef struct packed {
    logic             ewi;
    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] win;
  } cfg_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int BASE_LOG2 = 12,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int OPTS = 1 << SEL_W;
  localparam int PW   = BASE_LOG2 + OPTS - 1;

  logic [PW-1:0]   pcnt;
  logic [OPTS-1:0] tick_opt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt <= '0;
    else        pcnt <= pcnt + 1'b1;
  end

  for (genvar g = 0; g < OPTS; g++) begin : g_opt
    assign tick_opt[g] = &pcnt[BASE_LOG2+g-1:0];
  end

  assign tick = tick_opt[sel];
endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
  parameter int W = 7,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         warn_step,
  output logic         expire_step
);
  localparam logic [W-1:0] MID = W'(1) << (W - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= INIT;
    else if (load) cnt <= load_val;
    else if (tick) cnt <= cnt - 1'b1;
  end

  assign warn_step   = tick && !load && (cnt == MID + W'(1));
  assign expire_step = tick && !load && (cnt == MID);
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);
  localparam int PCW = $clog2(PULSE_LEN + 1);
  logic [PCW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           remain <= '0;
    else if (trig)        remain <= PCW'(PULSE_LEN);
    else if (remain != 0) remain <= remain - 1'b1;
  end

  assign pulse = (remain != 0);
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 12,
  parameter int PULSE_LEN = 4,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              wdg_rst,
  output logic              ew_irq
);
  logic             ctl_wr, cfg_wr, sts_wr;
  logic             armed_q, arm_next;
  logic             flag_q;
  cfg_t             cfg_q;
  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic             warn_step, expire_step;
  logic             bad_low, too_early, timeout, trig;
  logic [CNT_W-1:0] wr_val;
  logic             unused_wdata;

  assign ctl_wr = reg_en && reg_wr && (reg_addr == ADDR_W'(OFS_CTL));
  assign cfg_wr = reg_en && reg_wr && (reg_addr == ADDR_W'(OFS_CFG));
  assign sts_wr = reg_en && reg_wr && (reg_addr == ADDR_W'(OFS_STS));
  assign wr_val = reg_wdata[CNT_W-1:0];
  assign unused_wdata = ^reg_wdata[DATA_W-1:CFG_W];

  wdt_prescaler #(.BASE_LOG2(BASE_LOG2), .SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .sel(cfg_q.sel), .tick(tick)
  );

  wdt_downcount #(.W(CNT_W), .INIT(CNT_RESET)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(ctl_wr), .load_val(wr_val),
    .cnt(cnt), .warn_step(warn_step), .expire_step(expire_step)
  );

  // Arming is one-way; only rst_n clears it.
  assign arm_next  = armed_q || (ctl_wr && reg_wdata[CTL_ARM_BIT]);
  assign bad_low   = ctl_wr && arm_next && !wr_val[CNT_W-1];
  assign too_early = ctl_wr && armed_q && (cnt > cfg_q.win);
  assign timeout   = armed_q && expire_step;
  assign trig      = bad_low || too_early || timeout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cfg_q   <= '{ewi: 1'b0, sel: '0, win: WIN_RESET};
      flag_q  <= 1'b0;
    end else begin
      armed_q <= arm_next;
      if (cfg_wr) begin
        cfg_q.win <= reg_wdata[CNT_W-1:0];
        cfg_q.sel <= reg_wdata[CNT_W+SEL_W-1:CNT_W];
        cfg_q.ewi <= cfg_q.ewi || reg_wdata[CFG_W-1];
      end
      // A new warning at the same edge wins over a software clear.
      if (warn_step)                   flag_q <= 1'b1;
      else if (sts_wr && !reg_wdata[0]) flag_q <= 1'b0;
    end
  end

  wdt_rst_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .trig(trig), .pulse(wdg_rst)
  );

  assign ew_irq = flag_q && cfg_q.ewi;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(OFS_CTL): reg_rdata[CNT_W:0] = {armed_q, cnt};
      ADDR_W'(OFS_CFG): reg_rdata[CFG_W-1:0] = cfg_q;
      ADDR_W'(OFS_STS): reg_rdata[0] = flag_q;
      default:          reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int PULSE_LEN = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       armed,
  input logic [6:0] cnt,
  input logic       tick,
  input logic       load,
  input logic       trig,
  input logic       wdg_rst,
  input logic       ewi
);
  a_r2_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);

  a_r9_ewi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ewi |=> ewi);

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> (cnt == $past(cnt) - 7'd1));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt));

  a_r4_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && tick && !load && cnt == 7'h40) |=> wdg_rst);

  a_r11_armed_only: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> armed);

  if (PULSE_LEN >= 2) begin : g_len
    a_r10_pulse_holds: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdg_rst) |=> wdg_rst);
  end
endmodule

bind win_watchdog wdt_checker #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .armed(armed_q), .cnt(cnt), .tick(tick),
  .load(ctl_wr), .trig(trig), .wdg_rst(wdg_rst), .ewi(cfg_q.ewi)
);

// File: tb/win_watchdog_test.sv
`timescale 1ns/1ps
module win_watchdog_test;
  localparam int BASE = 2;
  localparam int PL   = 4;
  localparam int CYC  = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        wdg_rst, ew_irq;

  int checks = 0, failures = 0, ecount = 0;
  bit done = 0;

  win_watchdog #(.BASE_LOG2(BASE), .PULSE_LEN(PL), .ADDR_W(4), .DATA_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wdg_rst(wdg_rst), .ew_irq(ew_irq)
  );

  always #(CYC/2) clk = ~clk;
  always @(posedge clk) if (!rst_n) ecount <= 0; else ecount <= ecount + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; reg_en = 1'b0; reg_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, output int k);
    @(negedge clk); reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_en = 1'b0; reg_wr = 1'b0;
    k = ecount - 1;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_en = 1'b1; reg_wr = 1'b0; reg_addr = a; #1; d = reg_rdata; reg_en = 1'b0;
  endtask

  function automatic int ticks(input int k, input int n, input int p);
    return (n + 1) / p - (k + 1) / p;
  endfunction

  function automatic int nth_tick(input int k, input int i, input int p);
    return ((k + 1) / p + i) * p - 1;
  endfunction

  initial begin
    #(CYC * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int k, n, p, t2, t3;
    do_reset();
    // R1 reset state
    rd(4'h0, d); check("R1 ctl", d, 32'h7F);
    rd(4'h4, d); check("R1 cfg", d, 32'h7F);
    rd(4'h8, d); check("R1 sts", d, 32'h0);
    check("R1 rst", {31'b0, wdg_rst}, 0);
    // R3 free run from reset
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); n = ecount - 1; rd(4'h0, d);
      check("R3 from reset", d, 32'(7'h7F - 7'(ticks(-1, n, 4))));
    end

    // R3 R11 R12 sweep of select values while disarmed
    for (int s = 0; s < 4; s++) begin
      p = 1 << (BASE + s);
      wr(4'h4, 32'h7F | (s << 7), k);
      repeat (s + 1) @(negedge clk);
      wr(4'h0, 32'h43, k);
      for (int i = 0; i < 6 * p; i++) begin
        @(negedge clk); n = ecount - 1; rd(4'h0, d);
        check("R3 R12 count", d, 32'(7'(7'h43 - 7'(ticks(k, n, p)))));
        check("R11 no timeout disarmed", {31'b0, wdg_rst}, 0);
      end
      wr(4'h0, 32'h01, k);
      for (int i = 0; i < 3 * p; i++) begin
        @(negedge clk); n = ecount - 1; rd(4'h0, d);
        check("R3 wrap", d, 32'(7'(7'h01 - 7'(ticks(k, n, p)))));
        check("R11 no rst low write", {31'b0, wdg_rst}, 0);
      end
    end
    wr(4'h4, 32'h50, k);
    wr(4'h0, 32'h7F, k);
    wr(4'h0, 32'h7F, k);
    @(negedge clk); check("R11 early reload disarmed", {31'b0, wdg_rst}, 0);

    // R4 R7 R10 timeout, with and without interrupt enable
    for (int e = 0; e < 2; e++) begin
      do_reset();
      p = 4;
      wr(4'h4, e ? 32'h27F : 32'h07F, k);
      repeat (e + 2) @(negedge clk);
      wr(4'h0, 32'hC2, k);
      t2 = nth_tick(k, 2, p); t3 = nth_tick(k, 3, p);
      for (int i = 0; i < t3 + PL + 4 - k; i++) begin
        @(negedge clk); n = ecount - 1;
        check("R4 R10 pulse", {31'b0, wdg_rst}, 32'((n >= t3) && (n < t3 + PL)));
        rd(4'h8, d);
        check("R7 flag", d, 32'(n >= t2));
        check("R7 irq", {31'b0, ew_irq}, 32'((n >= t2) && (e == 1)));
      end
      rd(4'h0, d); check("R2 still armed", d[7], 1);
    end

    // R8 flag clear rules (flag still set from previous run)
    wr(4'h8, 32'h1, k); rd(4'h8, d); check("R8 write 1 keeps", d, 1);
    wr(4'h8, 32'h0, k); rd(4'h8, d); check("R8 write 0 clears", d, 0);
    wr(4'h8, 32'h1, k); rd(4'h8, d); check("R8 write 1 no set", d, 0);
    // R9 enable sticky
    wr(4'h4, 32'h07F, k); rd(4'h4, d); check("R9 enable sticky", d[9], 1);

    // R5 software reset on arming write with bit 6 clear
    do_reset();
    wr(4'h0, 32'hB0, k);
    for (int i = 0; i < PL + 2; i++) begin
      @(negedge clk); n = ecount - 1;
      check("R5 R10 sw reset", {31'b0, wdg_rst}, 32'(n < k + PL));
    end

    // R6 reload above window
    do_reset();
    wr(4'h4, 32'h1D0, k);
    wr(4'h0, 32'hD1, k);
    check("R6 arm no rst", {31'b0, wdg_rst}, 0);
    wr(4'h0, 32'hD1, k);
    check("R6 early reload rst", {31'b0, wdg_rst}, 1);

    // R6 R2 reload at window boundary is legal, clearing bit 7 keeps armed
    do_reset();
    wr(4'h4, 32'h1D0, k);
    wr(4'h0, 32'hD0, k);
    wr(4'h0, 32'h50, k);
    wr(4'h0, 32'h45, k);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R6 legal reload", {31'b0, wdg_rst}, 0);
    end
    rd(4'h0, d); check("R2 arm kept", d, 32'hC5);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule